// File: doc/BRIEF.md
# Display Mode Flag Controller

This block holds the display-mode flags of a graphics subsystem and lets a host change them one command byte at a time. A single write-only command channel (a one-cycle strobe plus a data byte) sets or clears individual bits of the second mode byte, the 16-color analog flag, the 256-color flag, the 256-color extension flag and the plasma-panel flag. Some of these commands act only when a gate holds: the 16-color flag needs the analog-display capability input, and the 256-color flag needs bit 3 of the second mode byte.

Whenever the 16-color flag is written, the block pulses a palette-redraw strobe and a memory-access remap strobe. Whenever the 256-color flag is written, it pulses the palette-redraw strobe and a full-graphics-redraw strobe. These pulses go to the display and memory logic that consume the flags.

A status pair gives read access to single flags. The host writes an 8-bit selector, and the status output returns the chosen flag in bit 0. Bit 1 of the dot-clock configuration is ORed into every status value. The first mode byte and the clock configuration are inputs owned by neighbouring logic; only the three bits of the first mode byte that can be reported enter the block.

Top module: `disp_mode_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the whole second mode byte, the 16-color, 256-color, extension and plasma flags, the selector and all three strobes. With selector 0x00 the status output then reads 0xFF.
- R2: A command in 0x00..0x0F writes data bit 0 into the bit of the second mode byte indexed by data bits 3:1. This write is unconditional.
- R3: A command in 0x00..0x0F with data bits 3:1 equal to 0 also writes data bit 0 into the 16-color flag, but only when the analog capability input is high. Such a write raises the palette-redraw and access-remap strobes for one cycle. Without the capability, the 16-color flag keeps its value and no strobe is raised.
- R4: Command 0x21 sets and 0x20 clears the 256-color flag, only while bit 3 of the second mode byte is 1. An accepted write raises the palette-redraw and full-redraw strobes for one cycle.
- R5: Command 0x69 sets and 0x68 clears the extension flag, with no gate and no strobe.
- R6: Commands 0x40 and 0x80 clear the plasma flag. Commands 0x41 and 0x81 set it.
- R7: Any other command byte changes no flag, no bit of the second mode byte and no strobe.
- R8: Status bit 0 by selector: 0x01/0x02/0x03 give bits 1/4/7 of the first mode byte (inputs m1_bits_i[0]/[1]/[2]); 0x04/0x07/0x08 give bits 0/2/3 of the second mode byte; 0x05 gives plasma; 0x09 gives clock bit 0; 0x0A gives the 256-color flag; 0x0B gives 1; 0x0D gives the extension flag. Selector 0x00 gives 0xFF.
- R9: Every other selector value gives 0, apart from the clock overlay of R10.
- R10: Bit 1 of the clock configuration is ORed into bit 1 of every status value.
- R11: A command and a selector write in the same cycle both take effect at that edge. The status output then shows the newly selected flag with its updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| analog_cap_i | input | 1 | Analog-display capability, gates the 16-color flag |
| m1_bits_i | input | 3 | Bits 1, 4, 7 of the first mode byte |
| clk_cfg_i | input | 2 | Dot-clock configuration bits |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_data_i | input | 8 | Command byte |
| sel_wr_i | input | 1 | Selector write strobe |
| sel_data_i | input | 8 | New selector value |
| status_o | output | 8 | Selected flag in bit 0, with clock overlay |
| mode2_o | output | 8 | Second mode byte |
| color16_o | output | 1 | 16-color analog flag |
| color256_o | output | 1 | 256-color flag |
| ext256_o | output | 1 | 256-color extension flag |
| plasma_o | output | 1 | Plasma-panel flag |
| pal_redraw_o | output | 1 | Palette-redraw pulse |
| full_redraw_o | output | 1 | Full-graphics-redraw pulse |
| access_remap_o | output | 1 | Memory-access remap pulse |

## Verification
A flag-changing command and a selector write can land on the same clock edge. In that case the status output must report the new selector's flag with the value the command has just produced. The bench provokes this by issuing a command together with a selector write: set bit 3 with selector 0x08, set 256-color with 0x0A, set extension with 0x0D, set bit 2 with 0x07. It judges the status, the flags and the strobes together at the following falling edge. The gated cases are placed right next to their enabling writes: 256-color before and after bit 3 is set, and 16-color with the capability low and then high.

// File: rtl/disp_mode_pkg.sv
package disp_mode_pkg;

    localparam int BYTE_W = 8;
    localparam int CLK_W  = 2;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    // command codes, bit 0 is the value written
    localparam logic [BYTE_W-2:0] OP_C256   = 7'h10;   // 0x20 / 0x21
    localparam logic [BYTE_W-2:0] OP_EXT    = 7'h34;   // 0x68 / 0x69
    localparam logic [BYTE_W-2:0] OP_PLASMA = 7'h20;   // 0x40 / 0x41
    localparam logic [BYTE_W-2:0] OP_PLALT  = 7'h40;   // 0x80 / 0x81

    // status selector codes
    localparam byte_t SEL_ALL   = 8'h00;
    localparam byte_t SEL_M1_1  = 8'h01;
    localparam byte_t SEL_M1_4  = 8'h02;
    localparam byte_t SEL_M1_7  = 8'h03;
    localparam byte_t SEL_M2_0  = 8'h04;
    localparam byte_t SEL_PLAS  = 8'h05;
    localparam byte_t SEL_M2_2  = 8'h07;
    localparam byte_t SEL_M2_3  = 8'h08;
    localparam byte_t SEL_CK0   = 8'h09;
    localparam byte_t SEL_C256  = 8'h0A;
    localparam byte_t SEL_ONE   = 8'h0B;
    localparam byte_t SEL_EXT   = 8'h0D;

    typedef struct packed {
        byte_t mode2;
        logic  c16;
        logic  c256;
        logic  ext;
        logic  plasma;
    } flags_t;

    typedef struct packed {
        logic             m2_we;
        logic [IDX_W-1:0] m2_idx;
        logic             c16_we;
        logic             c256_we;
        logic             ext_we;
        logic             pl_we;
        logic             val;
    } act_t;

    typedef struct packed {
        logic m1_b1;
        logic m1_b4;
        logic m1_b7;
        logic m2_b0;
        logic m2_b2;
        logic m2_b3;
        logic plasma;
        logic c256;
        logic ext;
        logic ck0;
        logic ck1;
    } stat_src_t;

    function automatic act_t decode_cmd(byte_t d, logic cap, logic gate256);
        act_t a;
        a     = '0;
        a.val = d[0];
        if (d[BYTE_W-1:4] == '0) begin
            a.m2_we  = 1'b1;
            a.m2_idx = d[3:1];
            a.c16_we = (d[3:1] == '0) && cap;
        end else begin
            case (d[BYTE_W-1:1])
                OP_C256:             a.c256_we = gate256;
                OP_EXT:              a.ext_we  = 1'b1;
                OP_PLASMA, OP_PLALT: a.pl_we   = 1'b1;
                default:             a         = '0;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/disp_cmd_decode.sv
module disp_cmd_decode
    import disp_mode_pkg::*;
(
    input  logic  valid_i,
    input  byte_t data_i,
    input  logic  cap_i,
    input  logic  gate256_i,
    output act_t  act_o
);
    always_comb begin
        if (valid_i) act_o = decode_cmd(data_i, cap_i, gate256_i);
        else         act_o = '0;
    end
endmodule

// File: rtl/disp_mode_regs.sv
module disp_mode_regs
    import disp_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  act_t   act_i,
    output flags_t flags_o,
    output logic   pal_o,
    output logic   full_o,
    output logic   remap_o
);
    flags_t f;

    always_ff @(posedge clk) begin
        if (rst) begin
            f       <= '0;
            pal_o   <= 1'b0;
            full_o  <= 1'b0;
            remap_o <= 1'b0;
        end else begin
            pal_o   <= 1'b0;
            full_o  <= 1'b0;
            remap_o <= 1'b0;
            if (act_i.m2_we) f.mode2[act_i.m2_idx] <= act_i.val;
            if (act_i.c16_we) begin
                f.c16   <= act_i.val;
                pal_o   <= 1'b1;
                remap_o <= 1'b1;
            end
            if (act_i.c256_we) begin
                f.c256 <= act_i.val;
                pal_o  <= 1'b1;
                full_o <= 1'b1;
            end
            if (act_i.ext_we) f.ext    <= act_i.val;
            if (act_i.pl_we)  f.plasma <= act_i.val;
        end
    end

    assign flags_o = f;

    // R1: reset leaves all flags clear
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (f == '0 && !pal_o && !full_o && !remap_o));

    // R3: a change of the 16-color flag comes with both of its strobes
    assert_c16_strobes_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(f.c16) |-> (pal_o && remap_o));

    // R4: a change of the 256-color flag comes with palette and full redraw
    assert_c256_strobes_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(f.c256) |-> (pal_o && full_o));

    // R4: the 256-color flag rises only when mode2 bit 3 was set
    assert_c256_gate_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(f.c256) |-> $past(f.mode2[3]));

    // R5: extension flag changes never raise a strobe of their own
    assert_ext_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(f.ext) && $stable(f.c16) && $stable(f.c256))
            |-> (!pal_o && !full_o && !remap_o));

    // R7: the full-redraw strobe is never raised by itself
    assert_full_with_pal_R7: assert property (@(posedge clk) disable iff (rst)
        full_o |-> pal_o);
endmodule

// File: rtl/disp_status_mux.sv
module disp_status_mux
    import disp_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  byte_t     sel_i,
    input  stat_src_t src_i,
    output byte_t     status_o
);
    byte_t pick;

    always_comb begin
        pick = '0;
        case (sel_i)
            SEL_ALL:  pick    = '1;
            SEL_M1_1: pick[0] = src_i.m1_b1;
            SEL_M1_4: pick[0] = src_i.m1_b4;
            SEL_M1_7: pick[0] = src_i.m1_b7;
            SEL_M2_0: pick[0] = src_i.m2_b0;
            SEL_PLAS: pick[0] = src_i.plasma;
            SEL_M2_2: pick[0] = src_i.m2_b2;
            SEL_M2_3: pick[0] = src_i.m2_b3;
            SEL_CK0:  pick[0] = src_i.ck0;
            SEL_C256: pick[0] = src_i.c256;
            SEL_ONE:  pick[0] = 1'b1;
            SEL_EXT:  pick[0] = src_i.ext;
            default:  pick    = '0;
        endcase
    end

    assign status_o = pick | {{(BYTE_W-2){1'b0}}, src_i.ck1, 1'b0};

    // R10: clock bit 1 always shows in status bit 1
    assert_ck_overlay_R10: assert property (@(posedge clk) disable iff (rst)
        src_i.ck1 |-> status_o[1]);

    // R9: an unlisted selector yields nothing but the overlay
    assert_unlisted_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 8'h06 || sel_i == 8'h0C || sel_i > 8'h0D)
            |-> (status_o[BYTE_W-1:2] == '0 && !status_o[0]));
endmodule

// File: rtl/disp_mode_ctrl.sv
module disp_mode_ctrl
    import disp_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       analog_cap_i,
    input  logic [2:0] m1_bits_i,
    input  logic [1:0] clk_cfg_i,
    input  logic       cmd_valid_i,
    input  logic [7:0] cmd_data_i,
    input  logic       sel_wr_i,
    input  logic [7:0] sel_data_i,
    output logic [7:0] status_o,
    output logic [7:0] mode2_o,
    output logic       color16_o,
    output logic       color256_o,
    output logic       ext256_o,
    output logic       plasma_o,
    output logic       pal_redraw_o,
    output logic       full_redraw_o,
    output logic       access_remap_o
);
    act_t      act;
    flags_t    flags;
    byte_t     sel_q;
    stat_src_t src;

    disp_cmd_decode u_dec (
        .valid_i   (cmd_valid_i),
        .data_i    (cmd_data_i),
        .cap_i     (analog_cap_i),
        .gate256_i (flags.mode2[3]),
        .act_o     (act)
    );

    disp_mode_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .act_i   (act),
        .flags_o (flags),
        .pal_o   (pal_redraw_o),
        .full_o  (full_redraw_o),
        .remap_o (access_remap_o)
    );

    always_ff @(posedge clk) begin
        if (rst)           sel_q <= '0;
        else if (sel_wr_i) sel_q <= sel_data_i;
    end

    always_comb begin
        src.m1_b1  = m1_bits_i[0];
        src.m1_b4  = m1_bits_i[1];
        src.m1_b7  = m1_bits_i[2];
        src.m2_b0  = flags.mode2[0];
        src.m2_b2  = flags.mode2[2];
        src.m2_b3  = flags.mode2[3];
        src.plasma = flags.plasma;
        src.c256   = flags.c256;
        src.ext    = flags.ext;
        src.ck0    = clk_cfg_i[0];
        src.ck1    = clk_cfg_i[CLK_W-1];
    end

    disp_status_mux u_mux (
        .clk      (clk),
        .rst      (rst),
        .sel_i    (sel_q),
        .src_i    (src),
        .status_o (status_o)
    );

    assign mode2_o    = flags.mode2;
    assign color16_o  = flags.c16;
    assign color256_o = flags.c256;
    assign ext256_o   = flags.ext;
    assign plasma_o   = flags.plasma;

    // R11: a selector write is visible on the next cycle
    assert_sel_load_R11: assert property (@(posedge clk) disable iff (rst)
        sel_wr_i |=> (sel_q == $past(sel_data_i)));
endmodule

// File: tb/disp_mode_ctrl_tb.sv
module disp_mode_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       analog_cap_i = 1'b1;
    logic [2:0] m1_bits_i = 3'b000;
    logic [1:0] clk_cfg_i = 2'b00;
    logic       cmd_valid_i = 1'b0;
    logic [7:0] cmd_data_i = 8'h00;
    logic       sel_wr_i = 1'b0;
    logic [7:0] sel_data_i = 8'h00;
    logic [7:0] status_o, mode2_o;
    logic       color16_o, color256_o, ext256_o, plasma_o;
    logic       pal_redraw_o, full_redraw_o, access_remap_o;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [23:0] exp;
        logic [23:0] mask;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    disp_mode_ctrl u_dut (
        .clk(clk), .rst(rst), .analog_cap_i(analog_cap_i), .m1_bits_i(m1_bits_i),
        .clk_cfg_i(clk_cfg_i), .cmd_valid_i(cmd_valid_i), .cmd_data_i(cmd_data_i),
        .sel_wr_i(sel_wr_i), .sel_data_i(sel_data_i), .status_o(status_o),
        .mode2_o(mode2_o), .color16_o(color16_o), .color256_o(color256_o),
        .ext256_o(ext256_o), .plasma_o(plasma_o), .pal_redraw_o(pal_redraw_o),
        .full_redraw_o(full_redraw_o), .access_remap_o(access_remap_o)
    );

    // observation word: [23:16] mode2, [14] remap, [13] full, [12] pal,
    // [11] plasma, [10] ext, [9] c256, [8] c16, [7:0] status
    wire [23:0] obs = {mode2_o, 1'b0, access_remap_o, full_redraw_o, pal_redraw_o,
                       plasma_o, ext256_o, color256_o, color16_o, status_o};

    // monitor: compares one expected item per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_tests++;
                if ((obs & it.mask) !== (it.exp & it.mask)) begin
                    n_fail++;
                    $display("FAIL %s: actual %06h expected %06h (mask %06h)",
                             it.tag, obs & it.mask, it.exp & it.mask, it.mask);
                end
            end
        end
    end

    task automatic step(input logic cv, input logic [7:0] cd,
                        input logic sv, input logic [7:0] sd,
                        input logic [2:0] m1, input logic [1:0] ck,
                        input logic [23:0] exp, input logic [23:0] mask,
                        input string tag);
        item_t it;
        @(negedge clk);
        cmd_valid_i = cv; cmd_data_i = cd;
        sel_wr_i    = sv; sel_data_i = sd;
        @(posedge clk);
        #1;
        cmd_valid_i = 1'b0; sel_wr_i = 1'b0;
        m1_bits_i = m1; clk_cfg_i = ck;
        it.exp = exp; it.mask = mask; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic do_reset(input string tag);
        item_t it;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0; clk_cfg_i = 2'b00;
        it.exp = 24'h0000FF; it.mask = 24'hFFFFFF; it.tag = tag;
        sb_q.push_back(it);
    endtask

    localparam logic [23:0] ALL = 24'hFFFFFF;
    localparam logic [23:0] ST  = 24'h0000FF;

    initial begin
        bit timed_out = 0;
        fork
            begin
                do_reset("R1 reset state");
                step(0, 8'h00, 1, 8'h04, 3'b111, 2'b00, 24'h000000, ALL, "R1 mode2 bit0 clear after reset");
                // 16-color gated by capability
                step(1, 8'h01, 0, 8'h00, 3'b111, 2'b00, 24'h015101, ALL, "R3 c16 set with cap, R2 bit0");
                analog_cap_i = 1'b0;
                step(1, 8'h00, 0, 8'h00, 3'b111, 2'b00, 24'h000100, ALL, "R3 c16 held without cap");
                // 256-color gated by mode2 bit 3
                step(1, 8'h21, 0, 8'h00, 3'b111, 2'b00, 24'h000100, ALL, "R4 0x21 ignored, gate low");
                step(1, 8'h07, 1, 8'h08, 3'b111, 2'b00, 24'h080101, ALL, "R2 R11 bit3 set with sel 08");
                step(1, 8'h21, 1, 8'h0A, 3'b111, 2'b00, 24'h083301, ALL, "R4 R11 c256 set with sel 0A");
                step(1, 8'h69, 1, 8'h0D, 3'b111, 2'b00, 24'h080701, ALL, "R5 R11 ext set with sel 0D");
                step(1, 8'h41, 1, 8'h05, 3'b111, 2'b00, 24'h080F01, ALL, "R6 plasma set 0x41");
                step(1, 8'h80, 0, 8'h00, 3'b111, 2'b00, 24'h080700, ALL, "R6 plasma clear 0x80");
                step(1, 8'h81, 0, 8'h00, 3'b111, 2'b00, 24'h080F01, ALL, "R6 plasma set 0x81");
                step(1, 8'h40, 0, 8'h00, 3'b111, 2'b00, 24'h080700, ALL, "R6 plasma clear 0x40");
                step(1, 8'h55, 0, 8'h00, 3'b111, 2'b00, 24'h080700, ALL, "R7 undefined 0x55");
                step(1, 8'h10, 0, 8'h00, 3'b111, 2'b00, 24'h080700, ALL, "R7 undefined 0x10");
                step(1, 8'hFF, 0, 8'h00, 3'b111, 2'b00, 24'h080700, ALL, "R7 undefined 0xFF");
                step(1, 8'h68, 1, 8'h0D, 3'b111, 2'b00, 24'h080300, ALL, "R5 ext clear 0x68");
                step(1, 8'h20, 0, 8'h00, 3'b111, 2'b00, 24'h083100, ALL, "R4 c256 clear with strobes");
                step(1, 8'h05, 1, 8'h07, 3'b111, 2'b00, 24'h0C0101, ALL, "R2 R11 bit2 set with sel 07");
                analog_cap_i = 1'b1;
                step(1, 8'h00, 0, 8'h00, 3'b111, 2'b00, 24'h0C5001, ALL, "R3 c16 clear with cap");
                // readback map
                step(0, 8'h00, 1, 8'h01, 3'b111, 2'b00, 24'h000001, ST, "R8 sel 01 m1 bit1");
                step(0, 8'h00, 1, 8'h02, 3'b111, 2'b00, 24'h000001, ST, "R8 sel 02 m1 bit4");
                step(0, 8'h00, 1, 8'h03, 3'b111, 2'b00, 24'h000001, ST, "R8 sel 03 m1 bit7");
                step(0, 8'h00, 0, 8'h00, 3'b000, 2'b00, 24'h000000, ST, "R8 sel 03 m1 bit7 low");
                step(0, 8'h00, 1, 8'h02, 3'b101, 2'b00, 24'h000000, ST, "R8 sel 02 m1 bit4 low");
                step(0, 8'h00, 1, 8'h09, 3'b000, 2'b01, 24'h000001, ST, "R8 sel 09 clock bit0");
                step(0, 8'h00, 0, 8'h00, 3'b000, 2'b11, 24'h000003, ST, "R10 sel 09 with overlay");
                step(0, 8'h00, 1, 8'h0B, 3'b000, 2'b00, 24'h000001, ST, "R8 sel 0B constant one");
                step(0, 8'h00, 1, 8'h06, 3'b111, 2'b00, 24'h000000, ST, "R9 sel 06 zero");
                step(0, 8'h00, 0, 8'h00, 3'b111, 2'b10, 24'h000002, ST, "R10 sel 06 overlay only");
                step(0, 8'h00, 1, 8'h0C, 3'b111, 2'b01, 24'h000000, ST, "R9 sel 0C zero");
                step(0, 8'h00, 1, 8'hFF, 3'b111, 2'b01, 24'h000000, ST, "R9 sel FF zero");
                step(0, 8'h00, 1, 8'h04, 3'b111, 2'b10, 24'h000002, ST, "R10 sel 04 overlay");
                step(0, 8'h00, 1, 8'h00, 3'b111, 2'b10, 24'h0000FF, ST, "R8 sel 00 all ones");
                // reset again from a busy state
                do_reset("R1 second reset");
                step(1, 8'h21, 1, 8'h08, 3'b111, 2'b00, 24'h000000, ALL, "R1 R4 bit3 clear gates 0x21");
                step(0, 8'h00, 1, 8'h0A, 3'b111, 2'b00, 24'h000000, ALL, "R1 c256 stays clear");
                repeat (3) @(negedge clk);
            end
            begin
                repeat (5000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule